// File: doc/BRIEF.md
# Scan-Chain Memory Test Controller

This block lets a handful of pins exercise a dual-port memory macro. A long shift register is filled one bit per clock from a serial input while scan mode is on. The filled frame is a complete command: a bank select that picks one of several memory instances, and for each of the two memory ports an address, write data, active-low chip-select, active-low write-enable and a per-byte write mask. The decoded fields drive the memory pins directly.

With scan off, a falling edge on the active-low strobe input launches the command on both ports for exactly one clock. One clock later the memory has its read data on its output ports. Raising the load input then copies each port's read data into that port's data field of the frame. All other fields are left as they are. Turning scan on again shifts the updated frame out, most significant bit first, on a single serial output. An external tester can therefore drive and check the memory through five inputs and one output.

The frame is 112 bits with the defaults. From the top it holds a 4-bit bank select, then port 0, then port 1. Each port section holds, from its top: a 16-bit address, 32-bit data, chip-select, write-enable and a 4-bit mask.

Top module: `scan_sram_ctrl`

## Requirements
- R1: After the active-low reset, both memory chip-select outputs are high and the frame holds zero everywhere except the chip-select and write-enable bits of both ports, which are 1.
- R2: While scan_en is high, each rising clock edge shifts the frame up by one bit and places scan_in in bit 0. After 112 shifts, the first bit entered sits in bit 111.
- R3: The memory outputs decode the frame continuously. bank_sel is frame bits 111:108. Port 0 uses bits 107:54: address 107:92, data 91:60, chip-select 59, write-enable 58, mask 57:54. Port 1 uses the same layout in bits 53:0. Mask bit i enables data byte i.
- R4: A high-to-low transition of strobe_n, sampled with scan_en low, drives mem_csn low for exactly one clock after that edge, for each port whose frame chip-select bit is 0. Holding strobe_n low does not fire again.
- R5: A strobe falling edge sampled while scan_en is high launches no operation.
- R6: A port whose frame chip-select bit is 1 keeps mem_csn high through a strobe, so its memory content is untouched even when its write-enable bit is 0.
- R7: With load_en high and scan_en low, a clock edge copies mem_rdata of each port into that port's 32-bit data field and leaves every other frame bit unchanged.
- R8: When scan_en and load_en are both high, the frame shifts and no capture takes place.
- R9: With scan_en and load_en both low, the frame holds its value.
- R10: scan_out always shows frame bit 111, so shifting presents the frame most significant bit first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan and memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | Shift enable, has priority over load |
| scan_in | input | 1 | Serial frame input |
| load_en | input | 1 | Capture read data into the frame |
| strobe_n | input | 1 | Active-low operation strobe, acts on its falling edge |
| scan_out | output | 1 | Serial frame output (frame MSB) |
| bank_sel | output | 4 | Memory instance select |
| mem_csn | output | 2 | Per-port active-low chip-select, bit k is port k |
| mem_wen | output | 2 | Per-port active-low write-enable |
| mem_wmask | output | 8 | Per-port byte mask, port k in bits 4k+3:4k |
| mem_addr | output | 32 | Per-port address, port k in bits 16k+15:16k |
| mem_wdata | output | 64 | Per-port write data, port k in bits 32k+31:32k |
| mem_rdata | input | 64 | Per-port read data, port k in bits 32k+31:32k |

## Verification
The bench writes and reads back distinct data in all five banks through both ports. Decoding the wrong field or swapping the ports shows up as wrong data on readback. It holds the strobe low for several clocks and counts chip-select cycles, which catches a level-triggered strobe that writes more than once. It also strobes while scan is on and checks that nothing fires. Further tests keep a port deselected while its write-enable is low, and write with a partial byte mask, to expose chip-select or mask gating errors. Shifting with load held high shows whether capture wrongly wins over shift, and an idle wait shows whether the frame drifts when it should hold.

// File: rtl/scan_sram_pkg.sv
package scan_sram_pkg;

    typedef enum logic [1:0] {
        FR_HOLD    = 2'd0,
        FR_SHIFT   = 2'd1,
        FR_CAPTURE = 2'd2
    } fr_op_e;

    // LSB position of port k's section; port 0 sits nearest the top.
    function automatic int port_base(input int k, input int nports, input int pw);
        return (nports - 1 - k) * pw;
    endfunction

endpackage

// File: rtl/scan_frame_reg.sv
module scan_frame_reg
    import scan_sram_pkg::*;
#(
    parameter int              FW      = 112,
    parameter logic [FW-1:0]   RST_VAL = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift_en,
    input  logic          shift_in,
    input  logic          cap_en,
    input  logic [FW-1:0] cap_mask,
    input  logic [FW-1:0] cap_val,
    output logic [FW-1:0] frame_q
);

    typedef struct packed {
        logic [FW-1:0] frame;
    } frame_st_t;

    frame_st_t st_d, st_q;
    fr_op_e    op;

    always_comb begin
        if (shift_en)    op = FR_SHIFT;
        else if (cap_en) op = FR_CAPTURE;
        else             op = FR_HOLD;

        st_d = st_q;
        case (op)
            FR_SHIFT:   st_d.frame = {st_q.frame[FW-2:0], shift_in};
            FR_CAPTURE: st_d.frame = (st_q.frame & ~cap_mask) | (cap_val & cap_mask);
            default:    st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.frame <= RST_VAL;
        else        st_q       <= st_d;
    end

    assign frame_q = st_q.frame;

    assert_shift_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> frame_q[0] == $past(shift_in));

    assert_shift_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> frame_q[FW-1:1] == $past(frame_q[FW-2:0]));

    assert_capture_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && !shift_en) |=> ((frame_q ^ $past(frame_q)) & ~$past(cap_mask)) == '0);

    assert_capture_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && !shift_en) |=> (frame_q & $past(cap_mask)) == ($past(cap_val) & $past(cap_mask)));

    assert_shift_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && shift_en) |=> frame_q[FW-1:1] == $past(frame_q[FW-2:0]));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !cap_en) |=> $stable(frame_q));

endmodule

// File: rtl/scan_strobe_gen.sv
module scan_strobe_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    input  logic block,
    output logic fire
);

    typedef struct packed {
        logic strobe;
        logic fire;
    } strobe_st_t;

    strobe_st_t st_d, st_q;

    always_comb begin
        st_d.strobe = strobe_n;
        st_d.fire   = st_q.strobe & ~strobe_n & ~block;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{strobe: 1'b1, fire: 1'b0};
        else        st_q <= st_d;
    end

    assign fire = st_q.fire;

    assert_single_fire_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);

    assert_fire_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> $past(!strobe_n) && $past(!block));

    assert_no_fire_in_scan_R5: assert property (@(posedge clk) disable iff (!rst_n)
        block |=> !fire);

endmodule

// File: rtl/scan_sram_ctrl.sv
module scan_sram_ctrl
    import scan_sram_pkg::*;
#(
    parameter int SEL_W     = 4,
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int MASK_W    = 4,
    parameter int NUM_PORTS = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          scan_en,
    input  logic                          scan_in,
    input  logic                          load_en,
    input  logic                          strobe_n,
    output logic                          scan_out,
    output logic [SEL_W-1:0]              bank_sel,
    output logic [NUM_PORTS-1:0]          mem_csn,
    output logic [NUM_PORTS-1:0]          mem_wen,
    output logic [NUM_PORTS*MASK_W-1:0]   mem_wmask,
    output logic [NUM_PORTS*ADDR_W-1:0]   mem_addr,
    output logic [NUM_PORTS*DATA_W-1:0]   mem_wdata,
    input  logic [NUM_PORTS*DATA_W-1:0]   mem_rdata
);

    localparam int PW       = ADDR_W + DATA_W + 2 + MASK_W;
    localparam int FW       = SEL_W + NUM_PORTS * PW;
    localparam int OFF_MASK = 0;
    localparam int OFF_WEN  = MASK_W;
    localparam int OFF_CSN  = MASK_W + 1;
    localparam int OFF_DATA = MASK_W + 2;
    localparam int OFF_ADDR = MASK_W + 2 + DATA_W;

    function automatic logic [FW-1:0] idle_frame();
        logic [FW-1:0] f;
        f = '0;
        for (int k = 0; k < NUM_PORTS; k++) begin
            f[port_base(k, NUM_PORTS, PW) + OFF_WEN] = 1'b1;
            f[port_base(k, NUM_PORTS, PW) + OFF_CSN] = 1'b1;
        end
        return f;
    endfunction

    localparam logic [FW-1:0] IDLE_FRAME = idle_frame();

    logic [FW-1:0] frame_q;
    logic [FW-1:0] cap_mask;
    logic [FW-1:0] cap_val;
    logic          fire;

    always_comb begin
        cap_mask = '0;
        cap_val  = '0;
        for (int k = 0; k < NUM_PORTS; k++) begin
            cap_mask[port_base(k, NUM_PORTS, PW) + OFF_DATA +: DATA_W] = '1;
            cap_val [port_base(k, NUM_PORTS, PW) + OFF_DATA +: DATA_W] =
                mem_rdata[k*DATA_W +: DATA_W];
        end
    end

    scan_frame_reg #(
        .FW      (FW),
        .RST_VAL (IDLE_FRAME)
    ) frame_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (scan_en),
        .shift_in (scan_in),
        .cap_en   (load_en),
        .cap_mask (cap_mask),
        .cap_val  (cap_val),
        .frame_q  (frame_q)
    );

    scan_strobe_gen strobe_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_n (strobe_n),
        .block    (scan_en),
        .fire     (fire)
    );

    assign scan_out = frame_q[FW-1];
    assign bank_sel = frame_q[FW-1 -: SEL_W];

    for (genvar g = 0; g < NUM_PORTS; g++) begin : gen_port
        localparam int BASE = (NUM_PORTS - 1 - g) * PW;
        assign mem_addr [g*ADDR_W +: ADDR_W] = frame_q[BASE + OFF_ADDR +: ADDR_W];
        assign mem_wdata[g*DATA_W +: DATA_W] = frame_q[BASE + OFF_DATA +: DATA_W];
        assign mem_wmask[g*MASK_W +: MASK_W] = frame_q[BASE + OFF_MASK +: MASK_W];
        assign mem_wen  [g]                  = frame_q[BASE + OFF_WEN];
        assign mem_csn  [g]                  = frame_q[BASE + OFF_CSN] | ~fire;
    end

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> mem_csn == '1);

endmodule

// File: tb/scan_sram_ctrl_tb_top.sv
`timescale 1ns/1ps
module scan_sram_ctrl_tb_top;

    localparam int FW = 112;

    logic        clk = 1'b0;
    logic        rst_n, scan_en, scan_in, load_en, strobe_n;
    logic        scan_out;
    logic [3:0]  bank_sel;
    logic [1:0]  mem_csn, mem_wen;
    logic [7:0]  mem_wmask;
    logic [31:0] mem_addr;
    logic [63:0] mem_wdata, mem_rdata;

    int checks = 0;
    int fails  = 0;
    int csn_cnt [2];

    always #10 clk = ~clk;

    scan_sram_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .scan_in(scan_in),
        .load_en(load_en), .strobe_n(strobe_n), .scan_out(scan_out),
        .bank_sel(bank_sel), .mem_csn(mem_csn), .mem_wen(mem_wen),
        .mem_wmask(mem_wmask), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    // Behavioural dual-port memory: five banks of 16 words, registered read.
    logic [31:0] mem [5][16];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < 5; b++)
                for (int a = 0; a < 16; a++) mem[b][a] <= '0;
            mem_rdata <= '0;
            csn_cnt[0] <= 0;
            csn_cnt[1] <= 0;
        end else begin
            for (int k = 0; k < 2; k++) begin
                if (!mem_csn[k]) begin
                    csn_cnt[k] <= csn_cnt[k] + 1;
                    if (bank_sel < 5) begin
                        if (!mem_wen[k]) begin
                            for (int by = 0; by < 4; by++)
                                if (mem_wmask[k*4+by])
                                    mem[bank_sel][mem_addr[k*16 +: 4]][by*8 +: 8] <=
                                        mem_wdata[k*32 + by*8 +: 8];
                        end else begin
                            mem_rdata[k*32 +: 32] <= mem[bank_sel][mem_addr[k*16 +: 4]];
                        end
                    end
                end
            end
        end
    end

    function automatic logic [FW-1:0] frm(
        input logic [3:0] s,
        input logic [15:0] a0, input logic [31:0] d0, input logic c0, w0, input logic [3:0] m0,
        input logic [15:0] a1, input logic [31:0] d1, input logic c1, w1, input logic [3:0] m1);
        return {s, a0, d0, c0, w0, m0, a1, d1, c1, w1, m1};
    endfunction

    localparam logic [FW-1:0] IDLE = {4'd0, 16'd0, 32'd0, 1'b1, 1'b1, 4'd0,
                                      16'd0, 32'd0, 1'b1, 1'b1, 4'd0};

    task automatic chk(input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Starts and ends on a falling edge; returns the frame that was shifted out.
    task automatic shift(input logic [FW-1:0] din, output logic [FW-1:0] dout);
        for (int j = 0; j < FW; j++) begin
            scan_en = 1'b1;
            scan_in = din[FW-1-j];
            dout[FW-1-j] = scan_out;
            @(posedge clk); @(negedge clk);
        end
        scan_en = 1'b0;
    endtask

    task automatic pulse(input int hold, input logic [1:0] exp_csn, input string req);
        strobe_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(req, FW'(mem_csn), FW'(exp_csn));
        for (int h = 1; h < hold; h++) begin
            @(posedge clk); @(negedge clk);
        end
        strobe_n = 1'b1;
        @(posedge clk); @(negedge clk);
        load_en = 1'b1;
        @(posedge clk); @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic do_read(input logic [3:0] s, input logic [15:0] a0, a1,
                           input logic [31:0] e0, e1, input string req);
        logic [FW-1:0] d;
        shift(frm(s, a0, 32'd0, 1'b0, 1'b1, 4'd0, a1, 32'd0, 1'b0, 1'b1, 4'd0), d);
        pulse(1, 2'b00, "R4 read fire");
        shift(IDLE, d);
        chk(req, d, frm(s, a0, e0, 1'b0, 1'b1, 4'd0, a1, e1, 1'b0, 1'b1, 4'd0));
    endtask

    task automatic t_reset();
        logic [FW-1:0] d;
        chk("R1 csn after reset", FW'(mem_csn), FW'(2'b11));
        chk("R1 bank after reset", FW'(bank_sel), '0);
        shift(IDLE, d);
        chk("R1 R10 reset frame readout", d, IDLE);
    endtask

    task automatic t_write_read(input logic [3:0] s);
        logic [FW-1:0] d;
        logic [15:0] a0, a1;
        logic [31:0] d0, d1;
        a0 = 16'(s);
        a1 = 16'(s) + 16'd8;
        d0 = 32'h1111_1111 * (32'(s) + 1);
        d1 = 32'hA0A0_0000 | 32'(s);
        shift(frm(s, a0, d0, 1'b0, 1'b0, 4'hF, a1, d1, 1'b0, 1'b0, 4'hF), d);
        chk("R3 bank decode", FW'(bank_sel), FW'(s));
        chk("R3 addr decode", FW'(mem_addr), FW'({a1, a0}));
        chk("R3 data decode", FW'(mem_wdata), FW'({d1, d0}));
        chk("R3 wen/mask decode", FW'({mem_wen, mem_wmask}), FW'({2'b00, 8'hFF}));
        chk("R4 no fire before strobe", FW'(mem_csn), FW'(2'b11));
        pulse(1, 2'b00, "R4 write fire");
        do_read(s, a0, a1, d0, d1, "R7 capture readback");
    endtask

    task automatic t_bank_isolation();
        do_read(4'd0, 16'd0, 16'd8, 32'h1111_1111, 32'hA0A0_0000, "R3 bank 0 isolated");
    endtask

    task automatic t_mask();
        logic [FW-1:0] d;
        shift(frm(4'd2, 16'd0, 32'd0, 1'b1, 1'b1, 4'd0,
                  16'd2, 32'hFFFF_FFFF, 1'b0, 1'b0, 4'b0101), d);
        pulse(1, 2'b01, "R6 port1-only fire");
        do_read(4'd2, 16'd2, 16'd10, 32'h33FF_33FF, 32'hA0A0_0002, "R3 byte mask");
    endtask

    task automatic t_idle_port();
        logic [FW-1:0] d;
        shift(frm(4'd3, 16'd3, 32'hDEAD_BEEF, 1'b1, 1'b0, 4'hF,
                  16'd5, 32'h0000_5555, 1'b0, 1'b0, 4'hF), d);
        pulse(1, 2'b01, "R6 deselected port csn high");
        do_read(4'd3, 16'd3, 16'd5, 32'h4444_4444, 32'h0000_5555, "R6 deselected port no write");
    endtask

    task automatic t_held_strobe();
        logic [FW-1:0] d;
        int c0, c1;
        shift(frm(4'd4, 16'd7, 32'h7777_0007, 1'b0, 1'b0, 4'hF,
                  16'd0, 32'd0, 1'b1, 1'b1, 4'd0), d);
        c0 = csn_cnt[0]; c1 = csn_cnt[1];
        pulse(4, 2'b10, "R4 held strobe first fire");
        chk("R4 held strobe fires once p0", FW'(csn_cnt[0] - c0), FW'(1));
        chk("R4 held strobe p1 idle", FW'(csn_cnt[1] - c1), FW'(0));
    endtask

    task automatic t_scan_strobe();
        logic [FW-1:0] d;
        int c0, c1;
        shift(frm(4'd1, 16'd1, 32'hBBBB_BBBB, 1'b0, 1'b0, 4'hF,
                  16'd9, 32'hCCCC_CCCC, 1'b0, 1'b0, 4'hF), d);
        c0 = csn_cnt[0]; c1 = csn_cnt[1];
        scan_en = 1'b1; scan_in = 1'b0; strobe_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); @(negedge clk);
            chk("R5 no fire during scan", FW'(mem_csn), FW'(2'b11));
        end
        scan_en = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R4 low level without edge no fire", FW'(mem_csn), FW'(2'b11));
        strobe_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R5 no op counted", FW'((csn_cnt[0] - c0) + (csn_cnt[1] - c1)), FW'(0));
        do_read(4'd1, 16'd1, 16'd9, 32'h2222_2222, 32'hA0A0_0001, "R5 memory untouched");
    endtask

    task automatic t_priority();
        logic [FW-1:0] f, d;
        f = frm(4'd1, 16'h0ABC, 32'h0BAD_F00D, 1'b1, 1'b1, 4'd0,
                16'h0123, 32'h1234_5678, 1'b1, 1'b1, 4'd0);
        load_en = 1'b1;
        shift(f, d);
        load_en = 1'b0;
        shift(IDLE, d);
        chk("R8 shift wins over load", d, f);
    endtask

    task automatic t_hold();
        logic [FW-1:0] f, d;
        f = frm(4'd3, 16'h00F0, 32'h5A5A_A5A5, 1'b1, 1'b0, 4'h3,
                16'h000F, 32'hC3C3_3C3C, 1'b1, 1'b1, 4'hC);
        shift(f, d);
        repeat (8) begin @(posedge clk); @(negedge clk); end
        chk("R9 outputs held", FW'({bank_sel, mem_addr, mem_wmask}),
            FW'({4'd3, 16'h000F, 16'h00F0, 4'hC, 4'h3}));
        shift(IDLE, d);
        chk("R9 R10 frame held", d, f);
    endtask

    initial begin
        rst_n = 1'b0; scan_en = 1'b0; scan_in = 1'b0; load_en = 1'b0; strobe_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        t_reset();
        for (int s = 0; s < 5; s++) t_write_read(4'(s));
        t_bank_isolation();
        t_mask();
        t_idle_port();
        t_held_strobe();
        t_scan_strobe();
        t_priority();
        t_hold();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule